// File: doc/BRIEF.md
# Mapper/Reducer Work Dispatcher

This block hands task identifiers to two separate pools of compute engines: a pool of mapper engines and a pool of reducer engines. Each pool has its own lane holding two first-in first-out queues. One queue lists the engines that are free to take work. The other lists the tasks that are waiting to run. On any cycle where both queues of a lane hold an entry, the lane takes the two head entries together. It then sends a one-cycle start strobe to the chosen engine and puts the task ID on the lane's task bus. An engine raises its finish bit when its work ends, and its ID goes back to the tail of the free queue. Engines with long and short run times are therefore refilled at the rate each one frees up.

The host pushes tasks into each lane through a valid/ready handshake. It raises `list_closed` once it has no more tasks to add. A small state machine controls the completion flag for the data-transfer controller. It has three states:
- `ST_OPEN`: the task list is still open.
- `ST_DRAIN`: the list is closed and work is still outstanding.
- `ST_DONE`: all work has completed.

The transitions are:
- OPEN to DRAIN when `list_closed` rises.
- DRAIN to DONE when both lanes are quiet and the list is closed. A lane is quiet when its pending queue is empty and every one of its engines is back in its free queue.
- DONE to DRAIN when new work appears while the list is still closed.
- DRAIN or DONE back to OPEN when `list_closed` falls.

A finish report from an engine that holds no task is dropped. It sets a sticky error flag.

Top module: `task_sched_top`

## Requirements
- R1: After reset, each free queue holds every engine ID of its pool in ascending order (0 first). Both pending queues are empty, both ready outputs are 1, and `all_done`, `err_spurious` and all start strobes are 0.
- R2: When a lane's free and pending queues are both non-empty, the lane pops both heads. On the next cycle it drives a one-cycle start strobe (bit i of the start vector is engine i) and puts the popped task ID on the lane's task bus. If the task was pushed into an empty pending queue while an engine was free, the strobe appears on the second clock edge after the push. A lane dispatches at most once per cycle.
- R3: Engines are reused in the order in which they returned to the free queue. When several engines of a lane finish in the same cycle, they return one per cycle, lowest index first.
- R4: Tasks are dispatched in the order in which they were accepted.
- R5: When a pending queue is full, its ready output is 0 and an offered task is not accepted, so it is never dispatched. Ready returns to 1 once a dispatch frees a slot.
- R6: A task push and an engine finish in the same cycle both take effect. The pushed task is then dispatched to the returning engine.
- R7: A finish report from an engine that is not running a task causes no dispatch and no change to the queues. It sets `err_spurious`, which stays 1 until reset.
- R8: `all_done` is 1 only while `list_closed` is 1, both pending queues are empty and every engine is back in its free queue. It falls on the cycle after `list_closed` falls.
- R9: The two lanes are independent. A full or stalled mapper lane does not change the reducer lane's ready output or its dispatching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_closed | input | 1 | Host has no further tasks (level) |
| map_task_valid | input | 1 | Mapper task offered |
| map_task_id | input | TASK_W | Mapper task identifier |
| map_task_ready | output | 1 | Mapper pending queue can accept |
| map_finish | input | N_MAP | Per-mapper completion pulse |
| map_start | output | N_MAP | Per-mapper one-cycle start strobe |
| map_start_task | output | TASK_W | Task ID for the strobed mapper |
| red_task_valid | input | 1 | Reducer task offered |
| red_task_id | input | TASK_W | Reducer task identifier |
| red_task_ready | output | 1 | Reducer pending queue can accept |
| red_finish | input | N_RED | Per-reducer completion pulse |
| red_start | output | N_RED | Per-reducer one-cycle start strobe |
| red_start_task | output | TASK_W | Task ID for the strobed reducer |
| all_done | output | 1 | All work complete and list closed |
| err_spurious | output | 1 | Sticky flag: finish from an idle engine |

## Verification
Within one lane, a task push and an engine finish can arrive in the same cycle. Both must land, and neither may be lost to the other. The bench provokes this with the only free reducer busy. It raises that reducer's finish bit on the same cycle that a new reducer task is offered, and expects that task to start on that reducer. A second collision is two mappers finishing together. Both must return to the free queue, and the bench judges this by the order in which the next two queued tasks reach those mappers (lowest index first).

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DONE  = 2'd2
    } done_state_t;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
    parameter int DW      = 8,
    parameter int DEPTH   = 4,
    parameter bit PRELOAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= PRELOAD ? DW'(i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= PRELOAD ? CW'(DEPTH) : '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sched_lane.sv
module sched_lane #(
    parameter int N_ENG      = 4,
    parameter int TASK_W     = 8,
    parameter int PEND_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [TASK_W-1:0] push_task,
    output logic              push_ready,
    input  logic [N_ENG-1:0]  finish,
    output logic [N_ENG-1:0]  start,
    output logic [TASK_W-1:0] start_task,
    output logic              quiet,
    output logic              spurious
);
    localparam int EW = (N_ENG > 1) ? $clog2(N_ENG) : 1;

    logic [N_ENG-1:0]  busy, ret_pend, ret_sel, disp_oh;
    logic [EW-1:0]     ret_idx, idle_head;
    logic [TASK_W-1:0] pend_head;
    logic              idle_empty, idle_full, pend_empty, pend_full;
    logic              dispatch;

    // Returning engines enter the free queue one per cycle, lowest index first.
    always_comb begin
        ret_idx = '0;
        for (int i = N_ENG - 1; i >= 0; i--) begin
            if (ret_pend[i]) ret_idx = EW'(i);
        end
        ret_sel = (|ret_pend) ? (N_ENG'(1) << ret_idx) : '0;
    end

    assign dispatch   = !idle_empty && !pend_empty;
    assign disp_oh    = N_ENG'(1) << idle_head;
    assign push_ready = !pend_full;
    assign spurious   = |(finish & ~busy);
    assign quiet      = pend_empty && idle_full;

    sched_fifo #(.DW(EW), .DEPTH(N_ENG), .PRELOAD(1'b1)) idle_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(|ret_pend), .din(ret_idx), .pop(dispatch),
        .dout(idle_head), .empty(idle_empty), .full(idle_full)
    );

    sched_fifo #(.DW(TASK_W), .DEPTH(PEND_DEPTH), .PRELOAD(1'b0)) pend_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(push_valid), .din(push_task), .pop(dispatch),
        .dout(pend_head), .empty(pend_empty), .full(pend_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= '0;
            ret_pend   <= '0;
            start      <= '0;
            start_task <= '0;
        end else begin
            busy     <= (busy & ~finish) | (dispatch ? disp_oh : '0);
            ret_pend <= (ret_pend & ~ret_sel) | (finish & busy);
            start    <= dispatch ? disp_oh : '0;
            if (dispatch) start_task <= pend_head;
        end
    end
endmodule

// File: rtl/task_sched_top.sv
module task_sched_top
    import sched_pkg::*;
#(
    parameter int N_MAP    = 4,
    parameter int N_RED    = 2,
    parameter int TASK_W   = 8,
    parameter int MAP_PEND = 4,
    parameter int RED_PEND = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              list_closed,
    input  logic              map_task_valid,
    input  logic [TASK_W-1:0] map_task_id,
    output logic              map_task_ready,
    input  logic [N_MAP-1:0]  map_finish,
    output logic [N_MAP-1:0]  map_start,
    output logic [TASK_W-1:0] map_start_task,
    input  logic              red_task_valid,
    input  logic [TASK_W-1:0] red_task_id,
    output logic              red_task_ready,
    input  logic [N_RED-1:0]  red_finish,
    output logic [N_RED-1:0]  red_start,
    output logic [TASK_W-1:0] red_start_task,
    output logic              all_done,
    output logic              err_spurious
);
    done_state_t state, state_nxt;
    logic map_quiet, red_quiet, map_spur, red_spur, lanes_quiet;

    sched_lane #(.N_ENG(N_MAP), .TASK_W(TASK_W), .PEND_DEPTH(MAP_PEND)) map_lane_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(map_task_valid), .push_task(map_task_id), .push_ready(map_task_ready),
        .finish(map_finish), .start(map_start), .start_task(map_start_task),
        .quiet(map_quiet), .spurious(map_spur)
    );

    sched_lane #(.N_ENG(N_RED), .TASK_W(TASK_W), .PEND_DEPTH(RED_PEND)) red_lane_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(red_task_valid), .push_task(red_task_id), .push_ready(red_task_ready),
        .finish(red_finish), .start(red_start), .start_task(red_start_task),
        .quiet(red_quiet), .spurious(red_spur)
    );

    assign lanes_quiet = map_quiet && red_quiet;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_OPEN;
            err_spurious <= 1'b0;
        end else begin
            state        <= state_nxt;
            err_spurious <= err_spurious | map_spur | red_spur;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:  if (list_closed) state_nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (!list_closed)     state_nxt = ST_OPEN;
                else if (lanes_quiet) state_nxt = ST_DONE;
            end
            ST_DONE: begin
                if (!list_closed)      state_nxt = ST_OPEN;
                else if (!lanes_quiet) state_nxt = ST_DRAIN;
            end
            default: state_nxt = ST_OPEN;
        endcase
    end

    always_comb begin
        all_done = (state == ST_DONE);
    end
endmodule

// File: rtl/task_sched_chk.sv
module task_sched_chk #(
    parameter int N_MAP = 4,
    parameter int N_RED = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             list_closed,
    input logic [N_MAP-1:0] map_finish,
    input logic [N_MAP-1:0] map_start,
    input logic [N_RED-1:0] red_finish,
    input logic [N_RED-1:0] red_start,
    input logic             all_done,
    input logic             err_spurious
);
    logic [N_MAP-1:0] sh_map_busy;
    logic [N_RED-1:0] sh_red_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_map_busy <= '0;
            sh_red_busy <= '0;
        end else begin
            sh_map_busy <= (sh_map_busy & ~map_finish) | map_start;
            sh_red_busy <= (sh_red_busy & ~red_finish) | red_start;
        end
    end

    p_map_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(map_start));
    p_red_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(red_start));
    p_map_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_start != '0) |=> ((map_start & $past(map_start)) == '0));
    p_map_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_start & sh_map_busy) == '0));
    p_red_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((red_start & sh_red_busy) == '0));
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_spurious |=> err_spurious);
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_spurious) |-> $past(((map_finish & ~sh_map_busy) != '0) ||
                                      ((red_finish & ~sh_red_busy) != '0)));
    p_done_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> $past(list_closed));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (map_start == '0 && red_start == '0 && sh_map_busy == '0 && sh_red_busy == '0));
endmodule

bind task_sched_top task_sched_chk #(.N_MAP(N_MAP), .N_RED(N_RED)) chk_i (
    .clk(clk), .rst_n(rst_n), .list_closed(list_closed),
    .map_finish(map_finish), .map_start(map_start),
    .red_finish(red_finish), .red_start(red_start),
    .all_done(all_done), .err_spurious(err_spurious)
);

// File: tb/task_sched_top_tb_top.sv
module task_sched_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       list_closed = 1'b0;
    logic       map_task_valid = 1'b0, red_task_valid = 1'b0;
    logic [7:0] map_task_id = '0, red_task_id = '0;
    logic       map_task_ready, red_task_ready;
    logic [3:0] map_finish = '0, map_start;
    logic [1:0] red_finish = '0, red_start;
    logic [7:0] map_start_task, red_start_task;
    logic       all_done, err_spurious;

    int checks = 0, failures = 0;
    bit reported = 1'b0;

    // high byte: task ID, low byte: expected mapper index (free queue order 0..3)
    localparam logic [15:0] VEC [0:3] = '{16'h1000, 16'h1101, 16'h1202, 16'h1303};

    always #5 clk = ~clk;

    task_sched_top dut_i (
        .clk(clk), .rst_n(rst_n), .list_closed(list_closed),
        .map_task_valid(map_task_valid), .map_task_id(map_task_id), .map_task_ready(map_task_ready),
        .map_finish(map_finish), .map_start(map_start), .map_start_task(map_start_task),
        .red_task_valid(red_task_valid), .red_task_id(red_task_id), .red_task_ready(red_task_ready),
        .red_finish(red_finish), .red_start(red_start), .red_start_task(red_start_task),
        .all_done(all_done), .err_spurious(err_spurious)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    endtask

    task automatic push_map(input logic [7:0] id);
        @(negedge clk); map_task_valid = 1'b1; map_task_id = id;
        @(negedge clk); map_task_valid = 1'b0;
    endtask

    task automatic push_red(input logic [7:0] id);
        @(negedge clk); red_task_valid = 1'b1; red_task_id = id;
        @(negedge clk); red_task_valid = 1'b0;
    endtask

    task automatic pulse_finish(input logic [3:0] m, input logic [1:0] r);
        @(negedge clk); map_finish = m; red_finish = r;
        @(negedge clk); map_finish = '0; red_finish = '0;
    endtask

    task automatic wait_map(input int eng, input logic [7:0] id, input string tag);
        bit got = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (|map_start) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got && map_start == (4'b1 << eng) && map_start_task == id, tag,
            {got, 15'd0, 4'd0, map_start, map_start_task}, {1'b1, 15'd0, 4'd0, 4'(4'b1 << eng), id});
        @(negedge clk);
    endtask

    task automatic wait_red(input int eng, input logic [7:0] id, input string tag);
        bit got = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (|red_start) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got && red_start == (2'b1 << eng) && red_start_task == id, tag,
            {got, 21'd0, red_start, red_start_task}, {1'b1, 21'd0, 2'(2'b1 << eng), id});
        @(negedge clk);
    endtask

    task automatic expect_no_map(input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (|map_start) seen = 1'b1;
        end
        chk(!seen, tag, 32'(seen), 32'd0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(map_task_ready && red_task_ready, "R1 ready", {map_task_ready, red_task_ready}, 2'b11);
        chk(!all_done && !err_spurious && map_start == 0 && red_start == 0, "R1 outputs",
            {all_done, err_spurious, map_start, red_start}, 0);

        // R1 R2: table walk, free mappers taken in ascending order
        for (int v = 0; v < 4; v++) begin
            push_map(VEC[v][15:8]);
            wait_map(int'(VEC[v][7:0]), VEC[v][15:8], "R1 R2 table dispatch");
        end

        // R4 R5: fill pending queue while all mappers busy
        for (int t = 0; t < 4; t++) push_map(8'h20 + 8'(t));
        chk(!map_task_ready, "R5 ready low when full", 32'(map_task_ready), 0);
        chk(red_task_ready, "R9 reducer ready unaffected", 32'(red_task_ready), 1);
        @(negedge clk); map_task_valid = 1'b1; map_task_id = 8'h24;
        @(negedge clk); @(negedge clk); map_task_valid = 1'b0;

        // R3 R4: mappers 1 and 3 finish together; lower index returns first
        pulse_finish(4'b1010, 2'b00);
        wait_map(1, 8'h20, "R3 R4 first return");
        wait_map(3, 8'h21, "R3 R4 second return");
        chk(map_task_ready, "R5 ready recovers", 32'(map_task_ready), 1);
        pulse_finish(4'b0001, 2'b00);
        wait_map(0, 8'h22, "R4 order 3");
        pulse_finish(4'b0100, 2'b00);
        wait_map(2, 8'h23, "R4 order 4");
        pulse_finish(4'b0010, 2'b00);
        expect_no_map("R5 refused task never dispatched");

        // R9 R2: reducer lane
        push_red(8'h30);
        wait_red(0, 8'h30, "R9 reducer 0");
        push_red(8'h31);
        wait_red(1, 8'h31, "R9 reducer 1");
        push_red(8'h32);
        pulse_finish(4'b0000, 2'b01);
        wait_red(0, 8'h32, "R3 reducer reuse");
        // R6: push and finish in the same cycle
        @(negedge clk); red_finish = 2'b10; red_task_valid = 1'b1; red_task_id = 8'h33;
        @(negedge clk); red_finish = 2'b00; red_task_valid = 1'b0;
        wait_red(1, 8'h33, "R6 same-cycle push and finish");

        // R7: spurious finish from idle mapper 1
        chk(!err_spurious, "R7 flag clear before", 32'(err_spurious), 0);
        pulse_finish(4'b0010, 2'b00);
        chk(err_spurious, "R7 flag set", 32'(err_spurious), 1);
        expect_no_map("R7 spurious finish causes no dispatch");
        chk(err_spurious, "R7 flag sticky", 32'(err_spurious), 1);

        // R8: done
        @(negedge clk); list_closed = 1'b1;
        repeat (4) @(negedge clk);
        chk(!all_done, "R8 not done while busy", 32'(all_done), 0);
        pulse_finish(4'b1101, 2'b11);
        begin
            bit got = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (all_done) begin got = 1'b1; break; end
                @(negedge clk);
            end
            chk(got, "R8 done after drain", 32'(got), 1);
        end
        // R1 R3: free queue of mappers now 1,0,2,3
        list_closed = 1'b0;
        @(negedge clk);
        chk(!all_done, "R8 done falls with list_closed", 32'(all_done), 0);
        push_map(8'h40);
        wait_map(1, 8'h40, "R3 free order after drain");
        report();
    end
endmodule